// File: doc/BRIEF.md
# Gated 16-bit Compare Timer

This block is one timer channel built around a 16-bit up-counter. The counter advances on a tick chosen from four sources: every bus clock, the bus clock divided by 16, the bus clock divided by 256, or each rising edge of the horizontal-blank input. An optional gate, taken from either blanking input, either lets the counter run only while the gate is low or clears the counter on chosen gate edges. A compare register raises a sticky equal flag and can send the counter back to zero. A wrap past the top value raises a sticky overflow flag. A capture strobe copies the live count into a hold register.

Software reaches the channel through four word registers picked by a 2-bit select: count (0), mode (1), compare (2) and hold (3). These are the register offsets 0x00, 0x10, 0x20 and 0x30 divided by 16. Reads are combinational. Writes take effect at the clock edge where the write enable is high. One interrupt output combines the two flags with their enables.

Top module: `gate_cmp_timer`

## Requirements
- R1: Mode bits [1:0] pick the tick source: 0 ticks every clock, 1 every 16 clocks, 2 every 256 clocks, 3 on each rising edge of the horizontal-blank input. A change of this field restarts the divider, so the first divided tick lands 17 (or 257) clock edges after the edge that wrote the field.
- R2: Count and compare hold 16 bits, written from write-data bits [15:0] and read back with bits [31:16] equal to zero. A write to count (select 0) loads the counter at that edge, and this takes priority over every other update.
- R3: When mode bit 7 (count enable) is clear, the counter holds its value. Gate edges do not clear it either.
- R4: Mode bit 2 turns the gate on and mode bit 3 picks its source (0 horizontal blank, 1 vertical blank). With gate mode 0 (bits [5:4] = 0), the counter advances only while the selected source is low, and the other blanking input has no effect.
- R5: Gate modes 1, 2 and 3 clear the counter to zero on the rising edge, the falling edge, or either edge of the selected source. Counting then carries on, and an edge that the chosen mode does not select does nothing.
- R6: With mode bit 6 set, a tick that finds the count equal to compare sends the counter to zero instead of count+1. With bit 6 clear, the counter runs past the compare value.
- R7: Mode bit 10 (equal flag) is set when a tick moves the count onto the compare value. Writing a mode word with bit 10 = 1 clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over the clear.
- R8: Mode bit 11 (overflow flag) is set when a tick wraps the count from 0xFFFF to 0. It is cleared by writing 1 to that bit and kept when 0 is written.
- R9: The interrupt output equals (bit 10 AND bit 8) OR (bit 11 AND bit 9). A mode read returns bits [9:0] as written, the two flags in bits 10 and 11, and zero above.
- R10: A one-cycle capture strobe copies the current count into the hold register (select 3). Writes to the hold register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 count, 1 mode, 2 compare, 3 hold |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| hblank_i | input | 1 | Horizontal-blank level, tick source and gate source |
| vblank_i | input | 1 | Vertical-blank level, gate source |
| capture_i | input | 1 | Capture strobe for the hold register |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the exact cycle positions of divided ticks, because the divider is not visible at the ports. The bench writes the clock-select field and then samples the count at single-cycle resolution around the 17th and 257th edges, which shows both the restart and the period. The gate edge modes interact with a counter that is already running. The stimulus therefore starts the count at a known value, toggles the blanking level at known edges and compares the count with the value expected from counting edges. Flag persistence is checked by stopping the counter with a mode write whose flag bits are zero, and only then writing the clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // register select codes (offset / 16)
   localparam logic [1:0] SEL_COUNT = 2'd0;
   localparam logic [1:0] SEL_MODE  = 2'd1;
   localparam logic [1:0] SEL_CMP   = 2'd2;
   localparam logic [1:0] SEL_HOLD  = 2'd3;

   // mode word bit positions
   localparam int MB_CLK_LO  = 0;
   localparam int MB_CLK_HI  = 1;
   localparam int MB_GATE_ON = 2;
   localparam int MB_GATE_SRC = 3;
   localparam int MB_GMODE_LO = 4;
   localparam int MB_GMODE_HI = 5;
   localparam int MB_ZRET    = 6;
   localparam int MB_RUN     = 7;
   localparam int MB_EQ_IE   = 8;
   localparam int MB_OV_IE   = 9;
   localparam int MB_EQ_FLAG = 10;
   localparam int MB_OV_FLAG = 11;
   localparam int MODE_CFG_W = 10;

   typedef enum logic [1:0] {
      TSRC_BUS  = 2'd0,
      TSRC_MID  = 2'd1,
      TSRC_SLOW = 2'd2,
      TSRC_HBL  = 2'd3
   } tick_src_e;

   typedef enum logic [1:0] {
      GM_LEVEL = 2'd0,
      GM_RISE  = 2'd1,
      GM_FALL  = 2'd2,
      GM_BOTH  = 2'd3
   } gate_mode_e;

   typedef struct packed {
      logic       ov_ie;
      logic       eq_ie;
      logic       run;
      logic       zret;
      gate_mode_e gmode;
      logic       gate_src;
      logic       gate_on;
      tick_src_e  tsrc;
   } mode_cfg_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
   import tmr_pkg::*;
#(
   parameter int DIV_MID  = 16,
   parameter int DIV_SLOW = 256
) (
   input  logic      clk,
   input  logic      rst_n,
   input  tick_src_e tsrc,
   input  logic      hbl_rise,
   output logic      tick
);

   localparam int DIVW = $clog2(DIV_SLOW);
   localparam int MIDW = $clog2(DIV_MID);

   if (DIV_MID < 2 || (DIV_MID & (DIV_MID - 1)) != 0) begin : g_bad_mid
      $error("tmr_prescaler: DIV_MID must be a power of two >= 2");
   end
   if (DIV_SLOW <= DIV_MID || (DIV_SLOW & (DIV_SLOW - 1)) != 0) begin : g_bad_slow
      $error("tmr_prescaler: DIV_SLOW must be a power of two above DIV_MID");
   end

   logic [DIVW-1:0] div_q;
   tick_src_e       tsrc_q;
   logic            tsrc_chg;

   assign tsrc_chg = (tsrc != tsrc_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         tsrc_q <= TSRC_BUS;
      end else begin
         tsrc_q <= tsrc;
         if (tsrc_chg) div_q <= '0;
         else          div_q <= div_q + DIVW'(1);
      end
   end

   always_comb begin
      unique case (tsrc)
         TSRC_BUS:  tick = 1'b1;
         TSRC_MID:  tick = !tsrc_chg && (&div_q[MIDW-1:0]);
         TSRC_SLOW: tick = !tsrc_chg && (&div_q);
         TSRC_HBL:  tick = hbl_rise;
         default:   tick = 1'b0;
      endcase
   end

endmodule

// File: rtl/tmr_gate.sv
module tmr_gate
   import tmr_pkg::*;
#(
   parameter bit GATE_PRESENT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gate_on,
   input  logic       gate_src,
   input  gate_mode_e gmode,
   input  logic       hblank,
   input  logic       vblank,
   output logic       allow,
   output logic       clear
);

   if (GATE_PRESENT) begin : g_gate
      logic hbl_q, vbl_q;
      logic lvl, lvl_q, rise, fall;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hbl_q <= 1'b0;
            vbl_q <= 1'b0;
         end else begin
            hbl_q <= hblank;
            vbl_q <= vblank;
         end
      end

      assign lvl   = gate_src ? vblank : hblank;
      assign lvl_q = gate_src ? vbl_q  : hbl_q;
      assign rise  = lvl & ~lvl_q;
      assign fall  = ~lvl & lvl_q;

      always_comb begin
         allow = 1'b1;
         clear = 1'b0;
         if (gate_on) begin
            unique case (gmode)
               GM_LEVEL: allow = ~lvl;
               GM_RISE:  clear = rise;
               GM_FALL:  clear = fall;
               GM_BOTH:  clear = rise | fall;
               default:  clear = 1'b0;
            endcase
         end
      end
   end else begin : g_nogate
      logic unused_gate_ins;
      assign unused_gate_ins = ^{clk, rst_n, gate_on, gate_src, gmode, hblank, vblank};
      assign allow = 1'b1;
      assign clear = 1'b0;
   end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clr,
   input  logic             adv,
   input  logic             zret,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             eq_hit,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_d, cnt_inc;

   assign cnt_inc = cnt + CNT_W'(1);

   always_comb begin
      cnt_d  = cnt;
      eq_hit = 1'b0;
      wrap   = 1'b0;
      if (load) begin
         cnt_d = load_val;
      end else if (clr) begin
         cnt_d = '0;
      end else if (adv) begin
         if (zret && (cnt == cmp)) begin
            cnt_d = '0;
         end else begin
            cnt_d  = cnt_inc;
            wrap   = &cnt;
            eq_hit = (cnt_inc == cmp);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
   end

endmodule

// File: rtl/gate_cmp_timer.sv
module gate_cmp_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int DW           = 32,
   parameter int DIV_MID      = 16,
   parameter int DIV_SLOW     = 256,
   parameter bit GATE_PRESENT = 1'b1,
   parameter bit HOLD_PRESENT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    reg_sel,
   input  logic          reg_we,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          hblank_i,
   input  logic          vblank_i,
   input  logic          capture_i,
   output logic          irq_o
);

   localparam int MODE_W = MB_OV_FLAG + 1;

   if (CNT_W < 2 || CNT_W >= DW) begin : g_bad_cnt
      $error("gate_cmp_timer: CNT_W must be in [2, DW-1]");
   end
   if (DW < MODE_W || DW < 2 * MODE_W) begin : g_bad_dw
      $error("gate_cmp_timer: DW too narrow for the mode word");
   end

   // register writes
   logic wr_cnt, wr_mode, wr_cmp;
   assign wr_cnt  = reg_we && (reg_sel == SEL_COUNT);
   assign wr_mode = reg_we && (reg_sel == SEL_MODE);
   assign wr_cmp  = reg_we && (reg_sel == SEL_CMP);

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^reg_wdata[DW-1:MODE_W];

   mode_cfg_t        cfg_q;
   logic [CNT_W-1:0] cmp_q;
   logic             equ_q, ovf_q;
   logic             hbl_q, hbl_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         cmp_q <= '0;
         hbl_q <= 1'b0;
      end else begin
         hbl_q <= hblank_i;
         if (wr_mode) cfg_q <= mode_cfg_t'(reg_wdata[MODE_CFG_W-1:0]);
         if (wr_cmp)  cmp_q <= reg_wdata[CNT_W-1:0];
      end
   end

   assign hbl_rise = hblank_i & ~hbl_q;

   // tick source
   logic tick;
   tmr_prescaler #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tsrc     (cfg_q.tsrc),
      .hbl_rise (hbl_rise),
      .tick     (tick)
   );

   // gate
   logic g_allow, g_clear;
   tmr_gate #(.GATE_PRESENT(GATE_PRESENT)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_on  (cfg_q.gate_on),
      .gate_src (cfg_q.gate_src),
      .gmode    (cfg_q.gmode),
      .hblank   (hblank_i),
      .vblank   (vblank_i),
      .allow    (g_allow),
      .clear    (g_clear)
   );

   // counter
   logic             adv, clr;
   logic [CNT_W-1:0] cnt_q;
   logic             eq_hit, wrap;

   assign adv = cfg_q.run & tick & g_allow;
   assign clr = cfg_q.run & g_clear;

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_cnt),
      .load_val (reg_wdata[CNT_W-1:0]),
      .clr      (clr),
      .adv      (adv),
      .zret     (cfg_q.zret),
      .cmp      (cmp_q),
      .cnt      (cnt_q),
      .eq_hit   (eq_hit),
      .wrap     (wrap)
   );

   // sticky flags: hardware set wins over write-one clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         equ_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         equ_q <= eq_hit | (equ_q & ~(wr_mode & reg_wdata[MB_EQ_FLAG]));
         ovf_q <= wrap   | (ovf_q & ~(wr_mode & reg_wdata[MB_OV_FLAG]));
      end
   end

   // hold register
   logic [CNT_W-1:0] hold_q;
   if (HOLD_PRESENT) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)         hold_q <= '0;
         else if (capture_i) hold_q <= cnt_q;
      end
   end else begin : g_nohold
      logic unused_capture;
      assign unused_capture = capture_i;
      assign hold_q = '0;
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel)
         SEL_COUNT: reg_rdata[CNT_W-1:0] = cnt_q;
         SEL_MODE:  reg_rdata[MODE_W-1:0] = {ovf_q, equ_q, cfg_q};
         SEL_CMP:   reg_rdata[CNT_W-1:0] = cmp_q;
         SEL_HOLD:  reg_rdata[CNT_W-1:0] = hold_q;
         default:   reg_rdata = '0;
      endcase
   end

   assign irq_o = (equ_q & cfg_q.eq_ie) | (ovf_q & cfg_q.ov_ie);

endmodule

// File: rtl/tmr_timer_chk.sv
module tmr_timer_chk #(
   parameter int CNT_W = 16,
   parameter int DW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       reg_sel,
   input logic             reg_we,
   input logic [DW-1:0]    reg_wdata,
   input logic [DW-1:0]    reg_rdata,
   input logic             capture_i,
   input logic             irq_o,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp,
   input logic [CNT_W-1:0] hold,
   input logic             equ,
   input logic             ovf,
   input logic             run,
   input logic             zret,
   input logic             adv,
   input logic             clr
);

   logic cnt_wr, mode_wr;
   assign cnt_wr  = reg_we && (reg_sel == 2'd0);
   assign mode_wr = reg_we && (reg_sel == 2'd1);

   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd0 || reg_sel == 2'd2) |-> (reg_rdata[DW-1:CNT_W] == '0));

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(reg_wdata[CNT_W-1:0])));

   p_hold_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));

   p_zero_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (zret && adv && (cnt == cmp) && !cnt_wr) |=> (cnt == '0));

   p_equ_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (equ && !(mode_wr && reg_wdata[10])) |=> equ);

   p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && (&cnt) && !(zret && (cnt == cmp)) && !cnt_wr && !clr) |=> ovf);

   p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (equ || ovf));

   p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_i |=> $stable(hold));

endmodule

bind gate_cmp_timer tmr_timer_chk #(.CNT_W(CNT_W), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .capture_i (capture_i),
   .irq_o     (irq_o),
   .cnt       (cnt_q),
   .cmp       (cmp_q),
   .hold      (hold_q),
   .equ       (equ_q),
   .ovf       (ovf_q),
   .run       (cfg_q.run),
   .zret      (cfg_q.zret),
   .adv       (adv),
   .clr       (clr)
);

// File: tb/gate_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module gate_cmp_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        hblank_i = 1'b0;
   logic        vblank_i = 1'b0;
   logic        capture_i = 1'b0;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gate_cmp_timer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .hblank_i  (hblank_i),
      .vblank_i  (vblank_i),
      .capture_i (capture_i),
      .irq_o     (irq_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the write edge
   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      reg_sel   = sel;
      reg_wdata = data;
      reg_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_we    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] data);
      reg_sel = sel;
      #1;
      data = reg_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_check(input string req, input string what,
                           input logic [1:0] sel, input logic [31:0] exp);
      logic [31:0] v;
      rd(sel, v);
      check(req, what, v, exp);
   endtask

   task automatic t_reset();
      rd_check("R2", "count after reset", 2'd0, 32'h0);
      rd_check("R9", "mode after reset", 2'd1, 32'h0);
      rd_check("R10", "hold after reset", 2'd3, 32'h0);
      check("R9", "irq after reset", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_regs();
      wr(2'd0, 32'hABCD_5678);
      rd_check("R2", "count upper zero", 2'd0, 32'h0000_5678);
      wr(2'd2, 32'hFFFF_0005);
      rd_check("R2", "compare upper zero", 2'd2, 32'h0000_0005);
   endtask

   task automatic t_run_enable();
      wr(2'd0, 32'd100);
      step(5);
      rd_check("R3", "stopped counter holds", 2'd0, 32'd100);
      wr(2'd1, 32'h080);
      step(5);
      rd_check("R1", "every-clock counting", 2'd0, 32'd105);
      wr(2'd1, 32'h000);
      step(4);
      rd_check("R3", "hold after stop", 2'd0, 32'd106);
   endtask

   task automatic t_compare();
      wr(2'd2, 32'd5);
      wr(2'd0, 32'd0);
      wr(2'd1, 32'h180);
      step(5);
      rd_check("R7", "count at compare", 2'd0, 32'd5);
      rd_check("R7", "equal flag set", 2'd1, 32'h580);
      check("R9", "irq from equal", {31'b0, irq_o}, 32'h1);
      step(2);
      rd_check("R6", "runs past compare without zero-return", 2'd0, 32'd7);
      wr(2'd1, 32'h100);
      rd_check("R7", "write 0 keeps equal flag", 2'd1, 32'h500);
      check("R9", "irq kept", {31'b0, irq_o}, 32'h1);
      wr(2'd1, 32'h500);
      rd_check("R7", "write 1 clears equal flag", 2'd1, 32'h100);
      check("R9", "irq dropped", {31'b0, irq_o}, 32'h0);
      // zero-return
      wr(2'd0, 32'd0);
      wr(2'd1, 32'h1C0);
      step(5);
      rd_check("R6", "reach compare", 2'd0, 32'd5);
      step(1);
      rd_check("R6", "zero return", 2'd0, 32'd0);
      step(2);
      rd_check("R6", "count after return", 2'd0, 32'd2);
      wr(2'd1, 32'h440);
      rd_check("R7", "flag cleared, stopped", 2'd1, 32'h040);
      rd_check("R3", "stopped value", 2'd0, 32'd3);
   endtask

   task automatic t_overflow();
      wr(2'd0, 32'h0000_FFFD);
      wr(2'd1, 32'h280);
      step(3);
      rd_check("R8", "wrapped count", 2'd0, 32'd0);
      rd_check("R8", "overflow flag set", 2'd1, 32'hA80);
      check("R9", "irq from overflow", {31'b0, irq_o}, 32'h1);
      wr(2'd1, 32'h000);
      rd_check("R8", "overflow flag kept on write 0", 2'd1, 32'h800);
      check("R9", "irq masked by bit 9", {31'b0, irq_o}, 32'h0);
      wr(2'd1, 32'h800);
      rd_check("R8", "overflow flag cleared", 2'd1, 32'h000);
   endtask

   task automatic t_capture();
      wr(2'd0, 32'h1234);
      capture_i = 1'b1;
      step(1);
      capture_i = 1'b0;
      rd_check("R10", "hold captured", 2'd3, 32'h1234);
      wr(2'd3, 32'hFFFF);
      rd_check("R10", "hold write ignored", 2'd3, 32'h1234);
      wr(2'd0, 32'h0042);
      rd_check("R10", "hold unchanged without strobe", 2'd3, 32'h1234);
   endtask

   task automatic t_gate_level();
      wr(2'd0, 32'd0);
      vblank_i = 1'b1;
      wr(2'd1, 32'h08C);
      step(10);
      rd_check("R4", "no count while gate high", 2'd0, 32'd0);
      vblank_i = 1'b0;
      step(5);
      rd_check("R4", "count while gate low", 2'd0, 32'd5);
      hblank_i = 1'b1;
      step(3);
      rd_check("R4", "other blank has no effect", 2'd0, 32'd8);
      hblank_i = 1'b0;
      wr(2'd1, 32'h000);
      rd_check("R4", "stopped", 2'd0, 32'd9);
   endtask

   task automatic t_gate_edge();
      wr(2'd0, 32'd50);
      wr(2'd1, 32'h094);
      step(3);
      rd_check("R5", "running before edge", 2'd0, 32'd53);
      hblank_i = 1'b1;
      step(1);
      rd_check("R5", "rise clears (mode 1)", 2'd0, 32'd0);
      step(3);
      rd_check("R5", "counts on after clear", 2'd0, 32'd3);
      hblank_i = 1'b0;
      step(2);
      rd_check("R5", "fall ignored (mode 1)", 2'd0, 32'd5);
      wr(2'd1, 32'h0B4);
      hblank_i = 1'b1;
      step(1);
      rd_check("R5", "rise clears (mode 3)", 2'd0, 32'd0);
      step(2);
      hblank_i = 1'b0;
      step(1);
      rd_check("R5", "fall clears (mode 3)", 2'd0, 32'd0);
      wr(2'd1, 32'h0A4);
      hblank_i = 1'b1;
      step(1);
      rd_check("R5", "rise ignored (mode 2)", 2'd0, 32'd2);
      hblank_i = 1'b0;
      step(1);
      rd_check("R5", "fall clears (mode 2)", 2'd0, 32'd0);
      wr(2'd1, 32'h000);
      rd_check("R3", "stopped after gate tests", 2'd0, 32'd1);
   endtask

   task automatic t_prescale();
      wr(2'd0, 32'd0);
      wr(2'd1, 32'h081);
      step(16);
      rd_check("R1", "div16 before first tick", 2'd0, 32'd0);
      step(1);
      rd_check("R1", "div16 first tick", 2'd0, 32'd1);
      step(15);
      rd_check("R1", "div16 between ticks", 2'd0, 32'd1);
      step(1);
      rd_check("R1", "div16 second tick", 2'd0, 32'd2);
      wr(2'd1, 32'h082);
      step(256);
      rd_check("R1", "div256 before first tick", 2'd0, 32'd2);
      step(1);
      rd_check("R1", "div256 first tick", 2'd0, 32'd3);
      wr(2'd1, 32'h083);
      for (int i = 0; i < 4; i++) begin
         hblank_i = 1'b1;
         step(1);
         hblank_i = 1'b0;
         step(2);
      end
      rd_check("R1", "one count per hblank rise", 2'd0, 32'd7);
      wr(2'd1, 32'h000);
      rd_check("R3", "stopped after hblank source", 2'd0, 32'd7);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_regs();
      t_run_enable();
      t_compare();
      t_overflow();
      t_capture();
      t_gate_level();
      t_gate_edge();
      t_prescale();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule